// File: doc/BRIEF.md
# Address-Plus-Data Serial Frame Master

This block is the host-side writer for an eight-channel converter that is loaded over a three-wire serial link. A client hands it a 3-bit channel number and an 8-bit level through a valid/ready request. The block captures both in the accepting cycle. It pulls the select line low and clocks the address, then the level, onto the data line with the most significant bit first. It then lifts select, and that edge commits the write inside the converter. The serial clock rests high. Each bit is placed on the data line before the clock drops, so the receiver takes the bit on the following rising edge.

A build parameter picks the frame shape. The compact shape sends only the three address bits, 11 bits in all. The byte shape sends a full leading byte that carries the address in its low three bits, then the level byte, 16 bits in all. Both shapes leave the converter in the same state. A second parameter sets how many system cycles each serial clock phase lasts. The block also drives two static control lines, sleep and clear, both active low, from level inputs.

Top module: `serialFrameMaster`

## Requirements
- R1: While reset is held and straight after it, selN, serClk, sleepN and clearN are high, reqReady is high and done is low.
- R2: A request is taken on a clock edge where reqValid and reqReady are both high. reqReady then stays low through the whole frame and the gap that follows it.
- R3: selN falls on the edge that accepts a request and stays low until every frame bit has been clocked. It then rises CLK_DIV cycles after the final rising serClk edge.
- R4: With BYTE_MODE=0 the frame is 11 bits: address bit 2 down to bit 0, then data bit 7 down to bit 0.
- R5: With BYTE_MODE=1 the frame is 16 bits: five zero bits, address bits 2..0, then data bits 7..0. The address therefore sits in bits [2:0] of the first byte.
- R6: serClk is high whenever selN is high. serData never changes on a rising serClk edge, and each frame bit is sampled on a rising serClk edge while selN is low.
- R7: Every low phase and every high phase of serClk inside a frame lasts CLK_DIV system cycles. The delay from selN falling to the first serClk fall also lasts CLK_DIV cycles.
- R8: done is high for exactly the one cycle in which selN has just returned high.
- R9: Between two frames, selN stays high for at least 2*CLK_DIV cycles, even when a request is already waiting.
- R10: sleepN and clearN equal the inverse of sleepReq and clearReq one cycle later, including during a frame.
- R11: Changes to reqAddr and reqData after acceptance have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 3 | Channel number |
| reqData | input | 8 | Level to write |
| sleepReq | input | 1 | Request converter sleep |
| clearReq | input | 1 | Request converter clear |
| done | output | 1 | One-cycle pulse when a write commits |
| serClk | output | 1 | Serial clock, idles high |
| serData | output | 1 | Serial data, MSB first |
| selN | output | 1 | Active-low select framing the write |
| sleepN | output | 1 | Active-low sleep line |
| clearN | output | 1 | Active-low clear line |

## Verification
The collision of interest is the end of one write against the start of the next. The done pulse and the rise of selN happen while a client is already holding reqValid high with fresh data. That situation tempts a design to accept the new request in the same cycle and shorten the select-high gap. The bench provokes this by keeping reqValid asserted across the end of a frame with the next vector already on the inputs. It then requires reqReady to stay low until the gap has run and the second frame to carry the second vector. It measures the select-high time between the two frames against 2*CLK_DIV. A second overlap is a static-line change landing inside a frame, and it must neither disturb the bits being shifted nor be delayed by them.

// File: rtl/sfmPkg.sv
package sfmPkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  // Control-to-datapath strobes, at most one edge action per cycle
  typedef struct packed {
    logic load;        // capture request, assert select, present first bit
    logic shift;       // advance to the next bit
    logic clkFall;     // drive serial clock low
    logic clkRise;     // drive serial clock high
    logic selRelease;  // deassert select, commit write
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } state_t;

  function automatic int frameWidth(input bit byteMode);
    return byteMode ? 2 * DATA_W : ADDR_W + DATA_W;
  endfunction

endpackage

// File: rtl/sfmControl.sv
module sfmControl
  import sfmPkg::*;
#(
  parameter int CLK_DIV   = 3,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output strobe_t strobes
);

  localparam int FRAME_W   = frameWidth(BYTE_MODE);
  localparam int BIT_W     = $clog2(FRAME_W + 1);
  localparam int CNT_W     = $clog2(2 * CLK_DIV + 1);
  localparam int HALF_LAST = CLK_DIV - 1;
  localparam int GAP_LAST  = 2 * CLK_DIV - 1;

  state_t           state;
  state_t           nextState;
  logic [CNT_W-1:0] divCnt;
  logic [BIT_W-1:0] bitsLeft;
  logic             halfDone;
  logic             gapDone;
  logic             lastBit;

  assign halfDone = (divCnt == CNT_W'(HALF_LAST));
  assign gapDone  = (divCnt == CNT_W'(GAP_LAST));
  assign lastBit  = (bitsLeft == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (reqValid) nextState = ST_LEAD;
      ST_LEAD: if (halfDone) nextState = ST_LOW;
      ST_LOW:  if (halfDone) nextState = ST_HIGH;
      ST_HIGH: if (halfDone) nextState = lastBit ? ST_GAP : ST_LOW;
      ST_GAP:  if (gapDone)  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.load       = (state == ST_IDLE) && reqValid;
    strobes.clkRise    = (state == ST_LOW) && halfDone;
    strobes.shift      = (state == ST_HIGH) && halfDone && !lastBit;
    strobes.clkFall    = ((state == ST_LEAD) && halfDone) || strobes.shift;
    strobes.selRelease = (state == ST_HIGH) && halfDone && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitsLeft <= '0;
    end else begin
      state <= nextState;
      if (nextState != state || nextState == ST_IDLE) divCnt <= '0;
      else                                            divCnt <= divCnt + 1'b1;
      if (strobes.load)         bitsLeft <= BIT_W'(FRAME_W);
      else if (strobes.clkRise) bitsLeft <= bitsLeft - 1'b1;
    end
  end

  // R2: accepting a request moves out of idle and drops ready
  assert_accept_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (state == ST_LEAD && !reqReady));

  // R6: only one serial edge action per cycle
  assert_single_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.clkFall, strobes.clkRise, strobes.selRelease}));

  // R4: a rising serial clock never occurs once every bit is out
  assert_no_extra_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clkRise |-> (bitsLeft != '0));

endmodule

// File: rtl/sfmDatapath.sv
module sfmDatapath
  import sfmPkg::*;
#(
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              sleepReq,
  input  logic              clearReq,
  output logic              serClk,
  output logic              serData,
  output logic              selN,
  output logic              done,
  output logic              sleepN,
  output logic              clearN
);

  localparam int FRAME_W = frameWidth(BYTE_MODE);
  localparam int PAD_W   = DATA_W - ADDR_W;

  logic [FRAME_W-1:0] frameWord;
  logic [FRAME_W-1:0] shiftReg;

  generate
    if (BYTE_MODE) begin : gByteFrame
      assign frameWord = {{PAD_W{1'b0}}, reqAddr, reqData};
    end else begin : gCompactFrame
      assign frameWord = {reqAddr, reqData};
    end
  endgenerate

  assign serData = shiftReg[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      serClk   <= 1'b1;
      selN     <= 1'b1;
      done     <= 1'b0;
    end else begin
      if (strobes.load)       shiftReg <= frameWord;
      else if (strobes.shift) shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      if (strobes.clkFall)      serClk <= 1'b0;
      else if (strobes.clkRise) serClk <= 1'b1;
      if (strobes.load)            selN <= 1'b0;
      else if (strobes.selRelease) selN <= 1'b1;
      done <= strobes.selRelease;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepN <= 1'b1;
      clearN <= 1'b1;
    end else begin
      sleepN <= !sleepReq;
      clearN <= !clearReq;
    end
  end

  // R6: clock rests high outside a frame
  assert_clock_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> serClk);

  // R6: data is steady across every rising serial edge
  assert_data_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> $stable(serData));

  // R8: done marks the commit edge of select
  assert_done_on_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(selN));

  // R10: static lines follow their requests one cycle later
  assert_static_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (sleepN == !$past(sleepReq) && clearN == !$past(clearReq)));

endmodule

// File: rtl/serialFrameMaster.sv
module serialFrameMaster
  import sfmPkg::*;
#(
  parameter int CLK_DIV   = 3,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [2:0] reqAddr,
  input  logic [7:0] reqData,
  input  logic       sleepReq,
  input  logic       clearReq,
  output logic       done,
  output logic       serClk,
  output logic       serData,
  output logic       selN,
  output logic       sleepN,
  output logic       clearN
);

  localparam int GAP_MIN = 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_MIN + 1);

  strobe_t strobes;

  sfmControl #(
    .CLK_DIV  (CLK_DIV),
    .BYTE_MODE(BYTE_MODE)
  ) uControl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strobes (strobes)
  );

  sfmDatapath #(
    .BYTE_MODE(BYTE_MODE)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .sleepReq(sleepReq),
    .clearReq(clearReq),
    .serClk  (serClk),
    .serData (serData),
    .selN    (selN),
    .done    (done),
    .sleepN  (sleepN),
    .clearN  (clearN)
  );

  // Select-high time counter, saturating, for the gap check
  logic [GAP_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= GAP_W'(GAP_MIN);
    else if (!selN) highCnt <= '0;
    else if (highCnt != GAP_W'(GAP_MIN)) highCnt <= highCnt + 1'b1;
  end

  // R9: minimum select-high time before a new frame
  assert_select_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selN) |-> ($past(highCnt) == GAP_W'(GAP_MIN)));

  // R2: no acceptance while a frame is running
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    !selN |-> !reqReady);

endmodule

// File: tb/serialFrameMaster_test.sv
`timescale 1ns/1ps

module frameSpy #(
  parameter int HALF = 3
) (
  input  logic        clk,
  input  logic        serClk,
  input  logic        serData,
  input  logic        selN,
  input  logic        done,
  output logic [15:0] frame,
  output int          bits,
  output int          frames,
  output int          badHalf,
  output int          doneMiss,
  output int          minGap
);
  int cyc = 0;
  int lastEdge = 0;
  int riseCyc = 0;
  bit inFrame = 0;
  bit seenEnd = 0;

  initial begin
    frame = '0; bits = 0; frames = 0; badHalf = 0; doneMiss = 0; minGap = 1000000;
  end

  always @(negedge clk) cyc++;

  always @(negedge selN) begin
    if (seenEnd && (cyc - riseCyc) < minGap) minGap = cyc - riseCyc;
    inFrame = 1; frame = '0; bits = 0; lastEdge = cyc;
  end

  always @(negedge serClk) if (inFrame && !selN) begin
    if (cyc - lastEdge != HALF) badHalf++;
    lastEdge = cyc;
  end

  always @(posedge serClk) if (inFrame && !selN) begin
    if (cyc - lastEdge != HALF) badHalf++;
    lastEdge = cyc;
    frame = {frame[14:0], serData};
    bits++;
  end

  always @(posedge selN) if (inFrame) begin
    if (cyc - lastEdge != HALF) badHalf++;
    inFrame = 0; seenEnd = 1; riseCyc = cyc; frames++;
    @(negedge clk);
    if (!done) doneMiss++;
  end
endmodule

module serialFrameMaster_test;
  localparam int DIV_A = 3;
  localparam int DIV_B = 2;
  localparam int NVEC  = 8;
  localparam logic [10:0] VECS [NVEC] = '{
    {3'd0, 8'h00}, {3'd7, 8'hFF}, {3'd5, 8'hA5}, {3'd2, 8'h5A},
    {3'd1, 8'h80}, {3'd6, 8'h01}, {3'd3, 8'h3C}, {3'd4, 8'hC3}
  };

  logic clk = 0;
  logic rstN = 0;
  logic validA = 0, validB = 0;
  logic readyA, readyB;
  logic [2:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic sleepReq = 0, clearReq = 0;
  logic doneA, doneB, sclkA, sclkB, sdA, sdB, selA, selB;
  logic sleepA, sleepB, clearA, clearB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] frmA, frmB;
  int bitsA, bitsB, cntA, cntB, badA, badB, dmA, dmB, gapA, gapB;

  always #2.5 clk = ~clk;

  serialFrameMaster #(.CLK_DIV(DIV_A), .BYTE_MODE(1'b0)) uut (
    .clk(clk), .rstN(rstN), .reqValid(validA), .reqReady(readyA),
    .reqAddr(reqAddr), .reqData(reqData), .sleepReq(sleepReq), .clearReq(clearReq),
    .done(doneA), .serClk(sclkA), .serData(sdA), .selN(selA),
    .sleepN(sleepA), .clearN(clearA));

  serialFrameMaster #(.CLK_DIV(DIV_B), .BYTE_MODE(1'b1)) uutB (
    .clk(clk), .rstN(rstN), .reqValid(validB), .reqReady(readyB),
    .reqAddr(reqAddr), .reqData(reqData), .sleepReq(sleepReq), .clearReq(clearReq),
    .done(doneB), .serClk(sclkB), .serData(sdB), .selN(selB),
    .sleepN(sleepB), .clearN(clearB));

  frameSpy #(.HALF(DIV_A)) spyA (.clk(clk), .serClk(sclkA), .serData(sdA), .selN(selA),
    .done(doneA), .frame(frmA), .bits(bitsA), .frames(cntA), .badHalf(badA),
    .doneMiss(dmA), .minGap(gapA));
  frameSpy #(.HALF(DIV_B)) spyB (.clk(clk), .serClk(sclkB), .serData(sdB), .selN(selB),
    .done(doneB), .frame(frmB), .bits(bitsB), .frames(cntB), .badHalf(badB),
    .doneMiss(dmB), .minGap(gapB));

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  function automatic logic rdy(input bit toB);
    return toB ? readyB : readyA;
  endfunction

  function automatic logic dn(input bit toB);
    return toB ? doneB : doneA;
  endfunction

  // Issue one request, scramble inputs after acceptance, wait for commit
  task automatic send(input bit toB, input logic [10:0] vec);
    @(negedge clk);
    reqAddr = vec[10:8]; reqData = vec[7:0];
    if (toB) validB = 1; else validA = 1;
    while (!rdy(toB)) @(negedge clk);
    @(negedge clk);
    validA = 0; validB = 0;
    reqAddr = ~vec[10:8]; reqData = ~vec[7:0];   // R11: must not matter
    check(!rdy(toB), "R2 ready low after accept", rdy(toB), 0);
    while (!dn(toB)) begin
      @(negedge clk);
      if (rdy(toB)) check(0, "R2 ready during frame", 1, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(selA && selB, "R1 selN", selA, 1);
    check(sclkA && sclkB, "R1 serClk", sclkA, 1);
    check(sleepA && clearA && sleepB && clearB, "R1 static lines", sleepA, 1);
    check(!doneA && !doneB, "R1 done", doneA, 0);
    rstN = 1;
    @(negedge clk);
    check(readyA && readyB, "R1 ready after reset", readyA, 1);
    check(selA && sclkA, "R1 idle after reset", selA, 1);

    // R4, R11: compact frames from the vector table
    for (int i = 0; i < NVEC; i++) begin
      send(1'b0, VECS[i]);
      check(frmA[10:0] == VECS[i], "R4 R11 compact frame", frmA[10:0], VECS[i]);
      check(bitsA == 11, "R4 compact bit count", bitsA, 11);
    end

    // R5, R11: byte frames, address in low bits of first byte
    for (int i = 0; i < NVEC; i++) begin
      send(1'b1, VECS[i]);
      check(frmB == {5'b0, VECS[i]}, "R5 R11 byte frame", frmB, {5'b0, VECS[i]});
      check(bitsB == 16, "R5 byte bit count", bitsB, 16);
    end

    // R9, R2: request held across commit with the next value waiting
    begin
      int firstCnt;
      @(negedge clk);
      reqAddr = 3'd6; reqData = 8'h96; validA = 1;
      while (!readyA) @(negedge clk);
      @(negedge clk);
      reqAddr = 3'd1; reqData = 8'h4E;
      while (!doneA) @(negedge clk);
      check(frmA[10:0] == {3'd6, 8'h96}, "R9 first of pair", frmA[10:0], {3'd6, 8'h96});
      firstCnt = cntA;
      check(!readyA, "R9 ready low at commit", readyA, 0);
      while (!readyA) @(negedge clk);
      @(negedge clk);
      validA = 0;
      while (!doneA) @(negedge clk);
      check(cntA == firstCnt + 1, "R9 second frame issued", cntA, firstCnt + 1);
      check(frmA[10:0] == {3'd1, 8'h4E}, "R9 second of pair", frmA[10:0], {3'd1, 8'h4E});
    end

    // R10: static lines change mid-frame without disturbing the frame
    @(negedge clk);
    reqAddr = 3'd5; reqData = 8'h3A; validA = 1;
    while (!readyA) @(negedge clk);
    @(negedge clk);
    validA = 0;
    repeat (4) @(negedge clk);
    sleepReq = 1; clearReq = 1;
    @(negedge clk);
    check(!sleepA && !clearA, "R10 lines asserted mid-frame", sleepA, 0);
    sleepReq = 0;
    @(negedge clk);
    check(sleepA && !clearA, "R10 sleep released", sleepA, 1);
    clearReq = 0;
    @(negedge clk);
    check(clearA && !selA, "R10 clear released during frame", clearA, 1);
    while (!doneA) @(negedge clk);
    check(frmA[10:0] == {3'd5, 8'h3A}, "R10 frame intact", frmA[10:0], {3'd5, 8'h3A});

    repeat (10) @(negedge clk);
    // R3, R6, R7: phase lengths, lead-in and tail measured at every edge
    check(badA == 0, "R7 R3 half periods compact", badA, 0);
    check(badB == 0, "R7 R3 half periods byte", badB, 0);
    // R8: done coincides with select rising
    check(dmA == 0 && dmB == 0, "R8 done at commit", dmA + dmB, 0);
    // R9: select-high gap
    check(gapA >= 2 * DIV_A, "R9 gap compact", gapA, 2 * DIV_A);
    check(gapB >= 2 * DIV_B, "R9 gap byte", gapB, 2 * DIV_B);
    // R6: clock rests high and ready returns after all traffic
    check(sclkA && sclkB && selA && selB, "R6 idle levels", sclkA, 1);
    check(readyA && readyB, "R2 ready restored", readyA, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule